// File: doc/BRIEF.md
# Partitioned Lane Arithmetic and Compare Unit

This block is a small SIMD integer unit for media registers. It takes two operands, splits them into independent lanes of either a quarter or a half of the full data width, and either adds or subtracts the lanes with wrap-around, or compares them lane by lane. A compare returns a packed bit mask with one bit per lane in the lowest bits of the result, with every other bit zero.

A size select chooses between a full-width register operation and a half-width one. In half-width mode only the low half of each operand takes part and the upper half of the result is zero, so the number of active lanes halves. The result is held in a register and appears one clock after the inputs are presented. There is no handshake: a new operation can be issued every cycle.

Top module: `lane_alu`

## Requirements
- R1: While rstN is low the result output is zero.
- R2: With opSel=0 (add), laneWide=0 and singleSize=0, the result holds four 16-bit lanes, lane r at bits [16r+15:16r], each equal to the lane sum modulo 2^16, with no carry passing from one lane into the next.
- R3: With opSel=1 (subtract), each active lane holds opA lane minus opB lane modulo the lane width, with no borrow passing between lanes.
- R4: With laneWide=1 and singleSize=0, add and subtract work on two 32-bit lanes at bits [31:0] and [63:32], carrying freely inside a lane but never across the bit-32 boundary.
- R5: With singleSize=1, only operand bits [31:0] are used and result bits [63:32] are zero; 16-bit lanes give two lanes and a 32-bit lane gives one.
- R6: opSel codes 2, 3, 4 and 5 compare opA lane against opB lane as signed two's-complement values, for greater-than, equal, less-or-equal and not-equal respectively; result bit r is set when lane r satisfies the predicate.
- R7: A compare clears every result bit above its lane count: bits [63:4] for four lanes, [63:2] for two lanes, [63:1] for one lane.
- R8: The result for inputs present at a rising clock edge appears after that edge and stays stable until the next edge, whatever the inputs do in between.
- R9: opSel codes 6 and 7 are reserved and give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| opSel | input | 3 | Operation: 0 add, 1 subtract, 2 greater-than, 3 equal, 4 less-or-equal, 5 not-equal, 6-7 reserved |
| laneWide | input | 1 | Lane width: 0 quarter-width (16-bit) lanes, 1 half-width (32-bit) lanes |
| singleSize | input | 1 | Register size: 0 full width, 1 half width |
| result | output | DATA_W | Registered result |

## Verification
The bench builds the unit with the default DATA_W of 64, which yields 16-bit and 32-bit lanes and therefore reaches all four combinations of lane width and register size. Operand patterns are chosen so that a lane overflows or underflows right at a lane boundary, so a leaked carry or borrow would show, and so that compares pit negative values against positive ones, exposing any unsigned interpretation. Half-width cases place garbage in the upper operand halves whose lanes would set mask bits if they were not excluded.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  localparam int NARROW_LANES = 4;
  localparam int WIDE_LANES   = 2;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_GT  = 3'd2;
  localparam logic [2:0] OP_EQ  = 3'd3;
  localparam logic [2:0] OP_LE  = 3'd4;
  localparam logic [2:0] OP_NE  = 3'd5;

  // Strobes from decode to datapath.
  typedef struct packed {
    logic                    arith;     // add or subtract
    logic                    subtract;  // subtract instead of add
    logic                    cmp;       // lane compare
    logic                    useGt;     // base predicate: greater-than (else equal)
    logic                    invert;    // negate the base predicate
    logic                    wide;      // half-width lanes
    logic                    single;    // half-width register
    logic                    zero;      // reserved code, force zero
    logic [NARROW_LANES-1:0] laneMask;  // active lanes
  } laneCtl_t;

endpackage

// File: rtl/lane_alu_ctrl.sv
module lane_alu_ctrl
  import lane_alu_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic       laneWide,
  input  logic       singleSize,
  output laneCtl_t   ctl
);

  always_comb begin
    ctl          = '0;
    ctl.wide     = laneWide;
    ctl.single   = singleSize;
    unique case ({laneWide, singleSize})
      2'b00:   ctl.laneMask = 4'b1111;
      2'b01:   ctl.laneMask = 4'b0011;
      2'b10:   ctl.laneMask = 4'b0011;
      default: ctl.laneMask = 4'b0001;
    endcase
    case (opSel)
      OP_ADD: ctl.arith = 1'b1;
      OP_SUB: begin
        ctl.arith    = 1'b1;
        ctl.subtract = 1'b1;
      end
      OP_GT: begin
        ctl.cmp   = 1'b1;
        ctl.useGt = 1'b1;
      end
      OP_EQ: ctl.cmp = 1'b1;
      OP_LE: begin
        ctl.cmp    = 1'b1;
        ctl.useGt  = 1'b1;
        ctl.invert = 1'b1;
      end
      OP_NE: begin
        ctl.cmp    = 1'b1;
        ctl.invert = 1'b1;
      end
      default: ctl.zero = 1'b1;
    endcase
  end

endmodule

// File: rtl/lane_alu_dp.sv
module lane_alu_dp
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  laneCtl_t          ctl,
  output logic [DATA_W-1:0] result
);

  localparam int NARROW_W = DATA_W / NARROW_LANES;
  localparam int WIDE_W   = DATA_W / WIDE_LANES;
  localparam int HALF_W   = DATA_W / 2;

  logic [DATA_W-1:0]       narSum;
  logic [DATA_W-1:0]       wideSum;
  logic [NARROW_LANES-1:0] narGt, narEq;
  logic [WIDE_LANES-1:0]   wideGt, wideEq;

  for (genvar i = 0; i < NARROW_LANES; i++) begin : g_narrow
    logic [NARROW_W-1:0] la, lb;
    assign la = opA[i*NARROW_W +: NARROW_W];
    assign lb = opB[i*NARROW_W +: NARROW_W];
    assign narSum[i*NARROW_W +: NARROW_W] = ctl.subtract ? la - lb : la + lb;
    assign narGt[i] = $signed(la) > $signed(lb);
    assign narEq[i] = la == lb;
  end

  for (genvar j = 0; j < WIDE_LANES; j++) begin : g_wide
    logic [WIDE_W-1:0] la, lb;
    assign la = opA[j*WIDE_W +: WIDE_W];
    assign lb = opB[j*WIDE_W +: WIDE_W];
    assign wideSum[j*WIDE_W +: WIDE_W] = ctl.subtract ? la - lb : la + lb;
    assign wideGt[j] = $signed(la) > $signed(lb);
    assign wideEq[j] = la == lb;
  end

  logic [NARROW_LANES-1:0] narHit, cmpMask;
  logic [WIDE_LANES-1:0]   wideHit;
  logic [DATA_W-1:0]       arithRes, nextRes;

  assign narHit  = (ctl.useGt ? narGt : narEq) ^ {NARROW_LANES{ctl.invert}};
  assign wideHit = (ctl.useGt ? wideGt : wideEq) ^ {WIDE_LANES{ctl.invert}};

  always_comb begin
    if (ctl.wide)
      cmpMask = {{(NARROW_LANES-WIDE_LANES){1'b0}}, wideHit}
                & ctl.laneMask;
    else
      cmpMask = narHit & ctl.laneMask;
    arithRes = ctl.wide ? wideSum : narSum;
    if (ctl.single)
      arithRes[DATA_W-1:HALF_W] = '0;
    if (ctl.zero)
      nextRes = '0;
    else if (ctl.cmp)
      nextRes = {{(DATA_W-NARROW_LANES){1'b0}}, cmpMask};
    else if (ctl.arith)
      nextRes = arithRes;
    else
      nextRes = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= nextRes;
  end

  // Marks that one full cycle has passed since reset release.
  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (result == '0 || rstN));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.arith, ctl.cmp, ctl.zero}));

  p_cmp_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmp |=> result[DATA_W-1:NARROW_LANES] == '0);

  p_wide_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cmp && ctl.wide) |=> result[DATA_W-1:WIDE_LANES] == '0);

  p_single_upper_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.single |=> result[DATA_W-1:HALF_W] == '0);

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.zero |=> result == '0);

  p_lane0_add_r2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(ctl.arith && !ctl.subtract && !ctl.wide))
      |-> result[NARROW_W-1:0] ==
          $past(opA[NARROW_W-1:0] + opB[NARROW_W-1:0]));

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opSel,
  input  logic              laneWide,
  input  logic              singleSize,
  output logic [DATA_W-1:0] result
);

  laneCtl_t ctl;

  lane_alu_ctrl u_ctrl (
    .opSel      (opSel),
    .laneWide   (laneWide),
    .singleSize (singleSize),
    .ctl        (ctl)
  );

  lane_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .ctl    (ctl),
    .result (result)
  );

endmodule

// File: tb/lane_alu_bench.sv
module lane_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [2:0]  opSel = 3'd0;
  logic        laneWide = 1'b0;
  logic        singleSize = 1'b0;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lane_alu #(.DATA_W(64)) u_lane_alu (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .laneWide(laneWide), .singleSize(singleSize), .result(result)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, capture at the rising edge, sample just after.
  task automatic run(input string req, input logic [63:0] a,
                     input logic [63:0] b, input logic [2:0] op,
                     input logic wide, input logic single,
                     input logic [63:0] exp);
    @(negedge clk);
    opA = a; opB = b; opSel = op; laneWide = wide; singleSize = single;
    @(posedge clk);
    #1;
    check(req, result, exp);
  endtask

  task automatic test_reset_r1();
    @(negedge clk);
    opA = 64'hFFFF_FFFF_FFFF_FFFF; opB = 64'h1; opSel = 3'd0;
    @(posedge clk); #1;
    check("R1 reset", result, 64'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic test_add16_r2();
    run("R2 add16", 64'h0001_7FFF_FFFF_1234, 64'h0001_0001_0001_1111,
        3'd0, 1'b0, 1'b0, 64'h0002_8000_0000_2345);
  endtask

  task automatic test_sub16_r3();
    run("R3 sub16", 64'h0000_0005_8000_1234, 64'h0001_0003_0001_0234,
        3'd1, 1'b0, 1'b0, 64'hFFFF_0002_7FFF_1000);
  endtask

  task automatic test_wide_r4();
    run("R4 add32", 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001,
        3'd0, 1'b1, 1'b0, 64'h0000_0000_0001_0000);
    run("R4 sub32", 64'h0, 64'h0000_0001_0000_0002,
        3'd1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic test_single_r5();
    run("R5 single add16", 64'hDEAD_BEEF_7FFF_0010, 64'h1234_5678_0001_0020,
        3'd0, 1'b0, 1'b1, 64'h0000_0000_8000_0030);
    run("R5 single add32", 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0002,
        3'd0, 1'b1, 1'b1, 64'h0000_0000_0000_0001);
    run("R5 single sub16", 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0001_0001,
        3'd1, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic test_cmp16_r6();
    logic [63:0] a = 64'h0005_FFFF_8000_0003;
    logic [63:0] b = 64'h0004_0000_7FFF_0003;
    run("R6 cmp16 gt", a, b, 3'd2, 1'b0, 1'b0, 64'h8);
    run("R6 cmp16 eq", a, b, 3'd3, 1'b0, 1'b0, 64'h1);
    run("R6 cmp16 le", a, b, 3'd4, 1'b0, 1'b0, 64'h7);
    run("R6 cmp16 ne", a, b, 3'd5, 1'b0, 1'b0, 64'hE);
  endtask

  task automatic test_cmp32_r7();
    logic [63:0] a = 64'h8000_0000_0000_0007;
    logic [63:0] b = 64'h0000_0001_0000_0007;
    run("R7 cmp32 gt", a, b, 3'd2, 1'b1, 1'b0, 64'h0);
    run("R7 cmp32 eq", a, b, 3'd3, 1'b1, 1'b0, 64'h1);
    run("R7 cmp32 le", a, b, 3'd4, 1'b1, 1'b0, 64'h3);
    run("R7 cmp32 ne", a, b, 3'd5, 1'b1, 1'b0, 64'h2);
  endtask

  task automatic test_single_cmp_r7();
    run("R7 single cmp16 le", 64'h0005_FFFF_8000_0003, 64'h0004_0000_7FFF_0003,
        3'd4, 1'b0, 1'b1, 64'h3);
    run("R7 single cmp16 ne", 64'h0005_FFFF_8000_0003, 64'h0004_0000_7FFF_0003,
        3'd5, 1'b0, 1'b1, 64'h2);
    run("R7 single cmp32 le", 64'h8000_0000_0000_0007, 64'h0000_0001_0000_0007,
        3'd4, 1'b1, 1'b1, 64'h1);
    run("R7 single cmp32 ne", 64'hFFFF_FFFF_0000_0007, 64'h0000_0000_0000_0007,
        3'd5, 1'b1, 1'b1, 64'h0);
  endtask

  task automatic test_latency_r8();
    run("R8 setup", 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001,
        3'd0, 1'b0, 1'b0, 64'h2);
    @(negedge clk);
    opA = 64'h0000_0000_0000_0010; opB = 64'h0000_0000_0000_0020;
    #1;
    check("R8 held before edge", result, 64'h2);
    @(posedge clk); #1;
    check("R8 updated after edge", result, 64'h30);
    @(negedge clk);
    opA = 64'h0000_0000_0000_0100;
    #1;
    check("R8 stable between edges", result, 64'h30);
  endtask

  task automatic test_reserved_r9();
    run("R9 code6", 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111,
        3'd6, 1'b0, 1'b0, 64'h0);
    run("R9 code7", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0,
        3'd7, 1'b1, 1'b0, 64'h0);
  endtask

  initial begin
    test_reset_r1();
    test_add16_r2();
    test_sub16_r3();
    test_wide_r4();
    test_single_r5();
    test_cmp16_r6();
    test_cmp32_r7();
    test_single_cmp_r7();
    test_latency_r8();
    test_reserved_r9();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule